// File: doc/BRIEF.md
# Byte-Register Multiply/Divide Coprocessor

This block is a small arithmetic engine that a host reaches through sixteen byte-wide registers. The host fills in operand bytes, then writes one particular byte to start a job. Writing the upper byte of the 16-bit multiplier starts a 16x16 multiply. Writing the upper byte of the 16-bit divisor starts a 32/16 divide. A control byte selects unsigned or two's-complement arithmetic. The 32-bit dividend register also supplies the multiplicand, through its two low bytes.

Both engines are sequential. The multiply is a shift-add loop of one bit per cycle. The divide is a restoring loop of one quotient bit per cycle. While either runs, `busy` is high. When the job ends, the 32-bit result, and for a divide the 16-bit remainder, are loaded together and a one-shot completion flag is raised. Reading the status register returns 0x80 once and then clears that flag.

Register map (byte address, name):

| Address | Register |
|---|---|
| 0x0 to 0x3 | dividend, least significant byte first; bytes 0x0 and 0x1 are also the multiplicand |
| 0x4 to 0x5 | multiplier, low byte then high byte; writing 0x5 starts a multiply |
| 0x6 to 0x7 | divisor, low byte then high byte; writing 0x7 starts a divide |
| 0x8 to 0xB | result, least significant byte first |
| 0xC to 0xD | remainder, low byte then high byte |
| 0xE | control; bit 0 set selects signed arithmetic |
| 0xF | status |

Top module: `muldiv_regs`

## Requirements
- R1: After a synchronous reset, all sixteen addresses read 0x00 and `busy` is low.
- R2: The dividend, multiplier, divisor and control bytes read back the last value written to them. Writes to the result bytes (0x8 to 0xB) and the remainder bytes (0xC, 0xD) leave those bytes unchanged.
- R3: Writing address 0x5 with control bit 0 clear multiplies the unsigned 16-bit multiplier by the unsigned value in bytes 0x0 and 0x1. The full 32-bit product appears in bytes 0x8 (least significant) to 0xB.
- R4: With control bit 0 set, the multiply treats both 16-bit operands as two's complement and produces the 32-bit two's-complement product.
- R5: Writing address 0x7 with control bit 0 clear divides the unsigned 32-bit dividend by the unsigned 16-bit divisor. It gives a 32-bit quotient in 0x8 to 0xB and a 16-bit remainder in 0xC and 0xD.
- R6: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. The case -2^31 / -1 gives quotient 0x80000000.
- R7: A divisor of zero gives quotient 0, and the remainder is the low 16 bits of the dividend, in either mode.
- R8: A write to control (0xE) while idle zeroes every operand, result and remainder byte, then stores the written value.
- R9: After a job completes, the first read of 0xF returns 0x80 and later reads return 0x00. Reads of 0xF while `busy` is high return 0x00.
- R10: `busy` rises on the clock edge that takes the start write. It stays high for 17 cycles for a multiply and 33 cycles for a divide. The result bytes change only on the edge where `busy` falls.
- R11: While `busy` is high, writes to 0x5, 0x7 and 0xE are ignored entirely: no register changes and no new job starts.
- R12: A read strobe presents the addressed byte on `rdata` one cycle later. `rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 4 | Byte register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | An arithmetic job is in progress |

## Verification
The multiply is tried with all-ones operands, which exercise every carry in the shift-add loop, with mixed-size values, and with a zero operand. Signed runs pair -1 with -1, -32768 with -32768, and a positive with a negative value, so that sign correction and the magnitude path for the most negative number each show up on their own. The divide is tried with quotients wider than 16 bits and with every sign combination of dividend and divisor, which separates truncation toward zero from floor behaviour. It is also tried with a zero divisor in both modes and with -2^31 / -1. Starts and control writes issued during a job, and status reads placed before and after completion, test the busy lockout apart from the arithmetic.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DVD0 = 4'h0;
  localparam logic [ADDR_W-1:0] A_DVD1 = 4'h1;
  localparam logic [ADDR_W-1:0] A_DVD2 = 4'h2;
  localparam logic [ADDR_W-1:0] A_DVD3 = 4'h3;
  localparam logic [ADDR_W-1:0] A_MLT0 = 4'h4;
  localparam logic [ADDR_W-1:0] A_MLT1 = 4'h5;
  localparam logic [ADDR_W-1:0] A_DVS0 = 4'h6;
  localparam logic [ADDR_W-1:0] A_DVS1 = 4'h7;
  localparam logic [ADDR_W-1:0] A_RES0 = 4'h8;
  localparam logic [ADDR_W-1:0] A_RES1 = 4'h9;
  localparam logic [ADDR_W-1:0] A_RES2 = 4'hA;
  localparam logic [ADDR_W-1:0] A_RES3 = 4'hB;
  localparam logic [ADDR_W-1:0] A_REM0 = 4'hC;
  localparam logic [ADDR_W-1:0] A_REM1 = 4'hD;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'hE;
  localparam logic [ADDR_W-1:0] A_STAT = 4'hF;

  typedef enum logic [1:0] {OP_IDLE, OP_MUL, OP_DIV} op_e;
endpackage

// File: rtl/muldiv_mul_seq.sv
// Shift-add multiplier of unsigned magnitudes, one multiplier bit per cycle.
module muldiv_mul_seq #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           run,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [2*W-1:0] mcand;
  logic [W-1:0]   mpl;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      done  <= 1'b0;
      prod  <= '0;
      mcand <= '0;
      mpl   <= '0;
      cnt   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        prod  <= '0;
        mcand <= {{W{1'b0}}, a};
        mpl   <= b;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        if (mpl[0]) prod <= prod + mcand;
        mcand <= mcand << 1;
        mpl   <= mpl >> 1;
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_div_seq.sv
// Restoring divider of unsigned magnitudes, one quotient bit per cycle.
module muldiv_div_seq #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          run,
  output logic          done,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt;
  logic [DW:0]   shifted;
  logic [DW:0]   diff;
  logic          ge;

  always_comb begin
    shifted = {rem, quo[NW-1]};
    diff    = shifted - {1'b0, den_q};
    ge      = shifted >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= num;
        rem   <= '0;
        den_q <= den;
        cnt   <= CW'(NW);
        run   <= 1'b1;
      end else if (run) begin
        rem <= ge ? diff[DW-1:0] : shifted[DW-1:0];
        quo <= {quo[NW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_regs.sv
module muldiv_regs
  import muldiv_pkg::*;
#(
  parameter int MUL_W = 16,
  parameter int DVD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int DVS_W = MUL_W;
  localparam int RES_W = 2 * MUL_W;

  logic [DVD_W-1:0] dvd_q;
  logic [MUL_W-1:0] mlt_q;
  logic [DVS_W-1:0] dvs_q;
  logic [RES_W-1:0] res_q;
  logic [DVS_W-1:0] rem_q;
  logic [7:0]       ctl_q;
  logic             flag_q;
  op_e              op_q;
  logic             neg_res_q, neg_rem_q, zero_q;
  logic [DVS_W-1:0] raw_lo_q;

  // start decode and operand magnitudes
  logic             go_mul, go_div;
  logic [MUL_W-1:0] m_a, m_b, mag_a, mag_b;
  logic [DVD_W-1:0] d_n, mag_n;
  logic [DVS_W-1:0] d_d, mag_d;
  logic             sgn;

  always_comb begin
    sgn    = ctl_q[0];
    go_mul = wr_en && !busy && (addr == A_MLT1);
    go_div = wr_en && !busy && (addr == A_DVS1);
    m_a    = {wdata, mlt_q[7:0]};
    m_b    = dvd_q[MUL_W-1:0];
    d_n    = dvd_q;
    d_d    = {wdata, dvs_q[7:0]};
    mag_a  = (sgn && m_a[MUL_W-1]) ? (~m_a + 1'b1) : m_a;
    mag_b  = (sgn && m_b[MUL_W-1]) ? (~m_b + 1'b1) : m_b;
    mag_n  = (sgn && d_n[DVD_W-1]) ? (~d_n + 1'b1) : d_n;
    mag_d  = (sgn && d_d[DVS_W-1]) ? (~d_d + 1'b1) : d_d;
  end

  logic             mul_run, mul_done, div_run, div_done;
  logic [RES_W-1:0] prod;
  logic [DVD_W-1:0] quo;
  logic [DVS_W-1:0] rem;

  muldiv_mul_seq #(.W(MUL_W)) u_mul (
    .clk(clk), .rst(rst), .start(go_mul), .a(mag_a), .b(mag_b),
    .run(mul_run), .done(mul_done), .prod(prod)
  );

  muldiv_div_seq #(.NW(DVD_W), .DW(DVS_W)) u_div (
    .clk(clk), .rst(rst), .start(go_div), .num(mag_n), .den(mag_d),
    .run(div_run), .done(div_done), .quo(quo), .rem(rem)
  );

  // sign-corrected results
  logic [RES_W-1:0] mul_fix;
  logic [DVD_W-1:0] quo_fix;
  logic [DVS_W-1:0] rem_fix;

  always_comb begin
    mul_fix = neg_res_q ? (~prod + 1'b1) : prod;
    quo_fix = zero_q ? '0 : (neg_res_q ? (~quo + 1'b1) : quo);
    rem_fix = zero_q ? raw_lo_q : (neg_rem_q ? (~rem + 1'b1) : rem);
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (addr)
      A_DVD0:  rd_mux = dvd_q[7:0];
      A_DVD1:  rd_mux = dvd_q[15:8];
      A_DVD2:  rd_mux = dvd_q[23:16];
      A_DVD3:  rd_mux = dvd_q[31:24];
      A_MLT0:  rd_mux = mlt_q[7:0];
      A_MLT1:  rd_mux = mlt_q[15:8];
      A_DVS0:  rd_mux = dvs_q[7:0];
      A_DVS1:  rd_mux = dvs_q[15:8];
      A_RES0:  rd_mux = res_q[7:0];
      A_RES1:  rd_mux = res_q[15:8];
      A_RES2:  rd_mux = res_q[23:16];
      A_RES3:  rd_mux = res_q[31:24];
      A_REM0:  rd_mux = rem_q[7:0];
      A_REM1:  rd_mux = rem_q[15:8];
      A_CTL:   rd_mux = ctl_q;
      default: rd_mux = {flag_q, 7'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q <= '0; mlt_q <= '0; dvs_q <= '0; res_q <= '0; rem_q <= '0;
      ctl_q <= '0; flag_q <= 1'b0; busy <= 1'b0; rdata <= '0;
      op_q <= OP_IDLE; neg_res_q <= 1'b0; neg_rem_q <= 1'b0;
      zero_q <= 1'b0; raw_lo_q <= '0;
    end else begin
      if (rd_en) begin
        rdata <= rd_mux;
        if (addr == A_STAT) flag_q <= 1'b0;
      end
      // completion: result load, flag set (wins over a same-edge status read)
      if (mul_done || div_done) begin
        busy   <= 1'b0;
        flag_q <= 1'b1;
        op_q   <= OP_IDLE;
        if (op_q == OP_MUL) res_q <= mul_fix;
        else begin
          res_q <= quo_fix;
          rem_q <= rem_fix;
        end
      end
      if (wr_en) begin
        case (addr)
          A_DVD0: dvd_q[7:0]   <= wdata;
          A_DVD1: dvd_q[15:8]  <= wdata;
          A_DVD2: dvd_q[23:16] <= wdata;
          A_DVD3: dvd_q[31:24] <= wdata;
          A_MLT0: mlt_q[7:0]   <= wdata;
          A_DVS0: dvs_q[7:0]   <= wdata;
          A_MLT1: if (!busy) begin
            mlt_q[15:8] <= wdata;
            busy        <= 1'b1;
            flag_q      <= 1'b0;
            op_q        <= OP_MUL;
            neg_res_q   <= sgn && (m_a[MUL_W-1] ^ m_b[MUL_W-1]);
          end
          A_DVS1: if (!busy) begin
            dvs_q[15:8] <= wdata;
            busy        <= 1'b1;
            flag_q      <= 1'b0;
            op_q        <= OP_DIV;
            neg_res_q   <= sgn && (d_n[DVD_W-1] ^ d_d[DVS_W-1]);
            neg_rem_q   <= sgn && d_n[DVD_W-1];
            zero_q      <= (d_d == '0);
            raw_lo_q    <= d_n[DVS_W-1:0];
          end
          A_CTL: if (!busy) begin
            dvd_q <= '0; mlt_q <= '0; dvs_q <= '0;
            res_q <= '0; rem_q <= '0;
            ctl_q <= wdata;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/muldiv_regs_chk.sv
module muldiv_regs_chk
  import muldiv_pkg::*;
#(
  parameter int MUL_CYC = 16,
  parameter int DIV_CYC = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              flag_q,
  input logic [31:0]       res_q,
  input logic [15:0]       rem_q,
  input logic              mul_run,
  input logic              div_run
);
  logic [7:0] len;
  always_ff @(posedge clk) begin
    if (rst) len <= '0;
    else if (busy) len <= len + 1'b1;
    else len <= '0;
  end

  // R9
  busy_flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !flag_q);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && (addr == A_MLT1 || addr == A_DVS1)));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(res_q));
  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $fell(busy));
  // R8
  ctl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTL && !busy) |=> (res_q == '0 && rem_q == '0));
  // R10
  one_engine_chk: assert property (@(posedge clk) disable iff (rst)
    !(mul_run && div_run));
  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (len == 8'(MUL_CYC + 1) || len == 8'(DIV_CYC + 1)));
endmodule

bind muldiv_regs muldiv_regs_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .busy(busy),
  .flag_q(flag_q), .res_q(res_q), .rem_q(rem_q),
  .mul_run(mul_run), .div_run(div_run)
);

// File: tb/sim_muldiv_regs.sv
`timescale 1ns/1ps
module sim_muldiv_regs;
  localparam int MUL_N = 16;
  localparam int DIV_N = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;

  always #2.5 clk = ~clk;

  muldiv_regs u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [31:0] m_dvd, m_res, p_res;
  logic [15:0] m_mlt, m_dvs, m_rem, p_rem;
  logic [7:0]  m_ctl, exp_rd;
  logic        m_flag, m_busy, chk_rd, p_div;
  int          m_cnt;

  function automatic logic [7:0] mread(input logic [3:0] a);
    logic [7:0] bytes [16];
    bytes[0] = m_dvd[7:0];   bytes[1] = m_dvd[15:8];
    bytes[2] = m_dvd[23:16]; bytes[3] = m_dvd[31:24];
    bytes[4] = m_mlt[7:0];   bytes[5] = m_mlt[15:8];
    bytes[6] = m_dvs[7:0];   bytes[7] = m_dvs[15:8];
    bytes[8] = m_res[7:0];   bytes[9] = m_res[15:8];
    bytes[10] = m_res[23:16]; bytes[11] = m_res[31:24];
    bytes[12] = m_rem[7:0];  bytes[13] = m_rem[15:8];
    bytes[14] = m_ctl;       bytes[15] = m_flag ? 8'h80 : 8'h00;
    return bytes[a];
  endfunction

  task automatic m_launch(input bit is_div, input logic [15:0] hi_word);
    longint a, b, q, r;
    logic [63:0] t;
    m_busy = 1'b1; m_flag = 1'b0; m_cnt = (is_div ? DIV_N : MUL_N) + 1;
    p_div = is_div;
    if (!is_div) begin
      a = m_ctl[0] ? longint'($signed(hi_word)) : longint'({48'd0, hi_word});
      b = m_ctl[0] ? longint'($signed(m_dvd[15:0])) : longint'({48'd0, m_dvd[15:0]});
      t = 64'(a * b);
      p_res = t[31:0];
    end else if (hi_word == 16'd0) begin
      p_res = 32'd0; p_rem = m_dvd[15:0];
    end else begin
      a = m_ctl[0] ? longint'($signed(m_dvd)) : longint'({32'd0, m_dvd});
      b = m_ctl[0] ? longint'($signed(hi_word)) : longint'({48'd0, hi_word});
      q = a / b; r = a % b;
      t = 64'(q); p_res = t[31:0];
      t = 64'(r); p_rem = t[15:0];
    end
  endtask

  always @(posedge clk) begin
    bit was_busy;
    if (rst) begin
      m_dvd = 0; m_res = 0; m_mlt = 0; m_dvs = 0; m_rem = 0; m_ctl = 0;
      m_flag = 0; m_busy = 0; chk_rd = 0; m_cnt = 0; exp_rd = 0;
    end else begin
      was_busy = m_busy;
      chk_rd = rd_en;
      if (rd_en) begin
        exp_rd = mread(addr);
        if (addr == 4'hF) m_flag = 1'b0;
      end
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_flag = 1'b1; m_res = p_res;
          if (p_div) m_rem = p_rem;
        end
      end
      if (wr_en) begin
        case (addr)
          4'h0: m_dvd[7:0] = wdata;
          4'h1: m_dvd[15:8] = wdata;
          4'h2: m_dvd[23:16] = wdata;
          4'h3: m_dvd[31:24] = wdata;
          4'h4: m_mlt[7:0] = wdata;
          4'h6: m_dvs[7:0] = wdata;
          4'h5: if (!was_busy) begin m_mlt[15:8] = wdata; m_launch(1'b0, m_mlt); end
          4'h7: if (!was_busy) begin m_dvs[15:8] = wdata; m_launch(1'b1, m_dvs); end
          4'hE: if (!was_busy) begin
            m_dvd = 0; m_mlt = 0; m_dvs = 0; m_res = 0; m_rem = 0; m_ctl = wdata;
          end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (busy !== m_busy) begin
        n_bad++;
        $display("FAIL R10 busy actual=%0b expected=%0b t=%0t", busy, m_busy, $time);
      end
      if (chk_rd) begin
        n_cmp++;
        if (rdata !== exp_rd) begin
          n_bad++;
          $display("FAIL %s rdata actual=%02h expected=%02h t=%0t",
                   cur_tag, rdata, exp_rd, $time);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_job(input string tag);
    cur_tag = "R9"; rd(4'hF);
    repeat (DIV_N + 3) @(negedge clk);
    rd(4'hF); rd(4'hF);
    cur_tag = tag;
    for (int i = 8; i < 14; i++) rd(4'(i));
  endtask

  task automatic do_mul(input logic [15:0] a, input logic [15:0] b, input string tag);
    wr(4'h0, b[7:0]); wr(4'h1, b[15:8]); wr(4'h4, a[7:0]); wr(4'h5, a[15:8]);
    finish_job(tag);
  endtask

  task automatic do_div(input logic [31:0] n, input logic [15:0] d, input string tag);
    wr(4'h0, n[7:0]); wr(4'h1, n[15:8]); wr(4'h2, n[23:16]); wr(4'h3, n[31:24]);
    wr(4'h6, d[7:0]); wr(4'h7, d[15:8]);
    finish_job(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_tag = "R1";
    for (int i = 0; i < 16; i++) rd(4'(i));
    // R2 readback and ignored result writes; R12 via every read
    cur_tag = "R2";
    wr(4'h0, 8'h11); wr(4'h2, 8'h33); wr(4'h4, 8'h55); wr(4'h6, 8'h77);
    wr(4'h8, 8'hAA); wr(4'hB, 8'hBB); wr(4'hC, 8'hCC); wr(4'hD, 8'hDD);
    for (int i = 0; i < 15; i++) rd(4'(i));
    cur_tag = "R8"; wr(4'hE, 8'h00);
    for (int i = 0; i < 16; i++) rd(4'(i));
    // R3 unsigned multiply
    do_mul(16'hFFFF, 16'hFFFF, "R3");
    do_mul(16'h1234, 16'h5678, "R3");
    do_mul(16'h0000, 16'hBEEF, "R3");
    // R5 unsigned divide
    do_div(32'hFFFF_FFFF, 16'h0003, "R5");
    do_div(32'h1234_5678, 16'hABCD, "R5");
    // R7 zero divisor unsigned
    do_div(32'hDEAD_BEEF, 16'h0000, "R7");
    // R8 control write wipes, then signed mode
    cur_tag = "R8"; wr(4'hE, 8'h01);
    for (int i = 0; i < 15; i++) rd(4'(i));
    // R4 signed multiply
    do_mul(16'hFFFF, 16'hFFFF, "R4");
    do_mul(16'h8000, 16'h8000, "R4");
    do_mul(16'h7FFF, 16'hFFFE, "R4");
    // R6 signed divide sign combinations
    do_div(32'hFFFF_FFF9, 16'h0002, "R6");
    do_div(32'h0000_0007, 16'hFFFE, "R6");
    do_div(32'hFFFF_FFF9, 16'hFFFE, "R6");
    do_div(32'h8000_0000, 16'hFFFF, "R6");
    // R7 zero divisor signed
    do_div(32'h8765_8321, 16'h0000, "R7");
    // R11 starts and control writes during a job are ignored
    cur_tag = "R11";
    wr(4'h0, 8'h03); wr(4'h1, 8'h00); wr(4'h4, 8'h05); wr(4'h5, 8'h00);
    wr(4'h5, 8'h7F); wr(4'h7, 8'h22); wr(4'hE, 8'h00);
    repeat (DIV_N + 3) @(negedge clk);
    for (int i = 0; i < 16; i++) rd(4'(i));
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule